// File: doc/BRIEF.md
# DLL Power-Mode Sequencer

This block decides the operating state of the delay-locked loop in a memory interface, based on a small set of configuration levels, a warm reset and an idle request from the power manager. The DLL can be in one of three states: powered down, idle (analog loop stopped, bias kept so that relock is quick), or running. The sequencer also holds the DLL's operating flavour, which is either tracked-lock or fixed-delay. It drives a stall level that keeps memory requests back until the DLL can be used.

A fixed priority settles conflicting inputs. Warm reset comes first, then power-down, then idle, then run. The tracked/fixed selection is sampled only at defined events, so a change made by software while the DLL runs does not disturb it. When the power manager raises its idle request, the sequencer drops into the low-power state chosen by the idle-action field. One cycle later it acknowledges, whatever the field holds. When the request falls, the sequencer goes back to the state that the configuration levels ask for. Frequency changes on the interface clock are only safe while the DLL sits in idle or power-down.

Leaving a low-power state passes through a start-up phase before requests are released. In fixed-delay flavour a counter loaded from the init-latency field sets the length of this phase. In tracked flavour the phase lasts until the lock-status input is high.

FSM states: `ST_PDN` (powered down), `ST_IDL` (idle), `ST_FIXWAIT` (fixed-delay start-up countdown), `ST_LOCKWAIT` (waiting for lock), `ST_ACTIVE` (running, requests released). The transitions are:
- any state to `ST_PDN` or `ST_IDL` whenever the resolved target is a low-power state;
- `ST_PDN`/`ST_IDL` to `ST_LOCKWAIT` on exit in tracked flavour;
- `ST_PDN`/`ST_IDL` to `ST_FIXWAIT` on exit in fixed flavour with a non-zero latency;
- `ST_PDN`/`ST_IDL` to `ST_ACTIVE` on exit in fixed flavour with zero latency;
- `ST_FIXWAIT` to `ST_ACTIVE` on the last count;
- `ST_LOCKWAIT` to `ST_ACTIVE` when the lock-status input is high.

Top module: `dll_pwr_seq`

## Requirements
- R1: While `rst_n` is low, the outputs take these values: `dll_pwrdn`=1, `dll_idle`=0, `dll_track`=0 (fixed-delay), `req_stall`=1, `idle_ack`=0, `idle_cfg_err`=0.
- R2: The configuration target is resolved as follows. `cfg_dll_en`=0 gives power-down. `cfg_dll_en`=1 with `cfg_dll_idle`=1 gives idle. Both at 1/0 gives run. Power-down therefore beats idle, and idle overrides enable. The outputs follow one clock after the inputs.
- R3: `warm_rst` high forces `dll_pwrdn`=1 on the next clock, whatever the other inputs are, and loads `dll_track` from `cfg_track_sel`.
- R4: With `dll_track`=0 and `cfg_init_lat`=N>0, leaving a low-power state keeps `req_stall` high for exactly N cycles after the state change.
- R5: With `dll_track`=0 and `cfg_init_lat`=0, `req_stall` falls on the same clock that leaves the low-power state.
- R6: With `dll_track`=1, `req_stall` stays high after leaving a low-power state until `dll_locked` is seen high on a clock edge. It falls on that edge.
- R7: `dll_track` loads `cfg_track_sel` only on these events: warm reset, the rising of an idle handshake (`idle_req` high while `idle_ack` low), entry into power-down, or entry into idle. At any other time a change is held pending.
- R8: With `idle_req` high, `cfg_idle_act`=0 gives power-down. `cfg_idle_act`=1 gives idle, unless the configuration asks for power-down, in which case power-down is taken.
- R9: `cfg_idle_act` values 2 and 3 take no action on `idle_req`; the configuration target applies. `idle_cfg_err` is high one cycle after each cycle in which `idle_req` is high with such a value, and low otherwise.
- R10: `idle_ack` is `idle_req` delayed by one clock, whatever `cfg_idle_act` holds. After the request falls, the DLL returns to the configuration target.
- R11: `req_stall` is high whenever `dll_pwrdn` or `dll_idle` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| warm_rst | input | 1 | Synchronous warm reset, active high |
| cfg_dll_en | input | 1 | DLL enable; 0 requests power-down |
| cfg_dll_idle | input | 1 | Idle request from configuration; overrides enable |
| cfg_track_sel | input | 1 | Flavour select: 1 tracked-lock, 0 fixed-delay |
| cfg_idle_act | input | 2 | Action on idle request: 0 power-down, 1 idle, 2/3 none |
| cfg_init_lat | input | LAT_W | Fixed-delay start-up stall length in cycles |
| idle_req | input | 1 | Idle request from the power manager |
| dll_locked | input | 1 | Lock status from the analog DLL |
| dll_pwrdn | output | 1 | DLL power-down control |
| dll_idle | output | 1 | DLL idle control |
| dll_track | output | 1 | Applied flavour: 1 tracked-lock, 0 fixed-delay |
| idle_ack | output | 1 | Idle acknowledge to the power manager |
| req_stall | output | 1 | Holds off memory requests |
| idle_cfg_err | output | 1 | Illegal idle action seen under an idle request |

## Verification
The assertions check several rules on every cycle:
- warm reset forcing power-down;
- the acknowledge timing and the error flag timing;
- the power-down and idle choices for idle-action codes 0 and 1;
- that requests stay stalled in low-power states;
- that the flavour changes only on one of the four latch events;
- that a tracked-flavour release never comes without lock.

Other properties depend on a history longer than a property can hold. These are the exact length of the fixed-delay stall, the zero-latency release, a pending flavour change surviving several run cycles, and the return to the configured state after a handshake. The bench's scenarios show these, with its reference model compared against the outputs on every clock.

// File: rtl/dll_pwr_pkg.sv
package dll_pwr_pkg;

    typedef enum logic [2:0] {
        ST_PDN      = 3'd0,
        ST_IDL      = 3'd1,
        ST_FIXWAIT  = 3'd2,
        ST_LOCKWAIT = 3'd3,
        ST_ACTIVE   = 3'd4
    } dll_st_e;

    typedef enum logic [1:0] {
        TGT_PDN = 2'd0,
        TGT_IDL = 2'd1,
        TGT_ACT = 2'd2
    } dll_tgt_e;

    localparam logic [1:0] ACT_PDN = 2'd0;
    localparam logic [1:0] ACT_IDL = 2'd1;

endpackage

// File: rtl/dll_tgt_sel.sv
module dll_tgt_sel
    import dll_pwr_pkg::*;
(
    input  logic       warm_rst,
    input  logic       cfg_dll_en,
    input  logic       cfg_dll_idle,
    input  logic [1:0] cfg_idle_act,
    input  logic       idle_req,
    output dll_tgt_e   tgt,
    output logic       bad_act
);

    dll_tgt_e cfg_tgt;

    // configuration priority: power-down, then idle, then run
    always_comb begin
        if (!cfg_dll_en)
            cfg_tgt = TGT_PDN;
        else if (cfg_dll_idle)
            cfg_tgt = TGT_IDL;
        else
            cfg_tgt = TGT_ACT;
    end

    assign bad_act = idle_req && (cfg_idle_act != ACT_PDN) && (cfg_idle_act != ACT_IDL);

    always_comb begin
        if (warm_rst)
            tgt = TGT_PDN;
        else if (idle_req && cfg_idle_act == ACT_PDN)
            tgt = TGT_PDN;
        else if (idle_req && cfg_idle_act == ACT_IDL)
            tgt = (cfg_tgt == TGT_PDN) ? TGT_PDN : TGT_IDL;
        else
            tgt = cfg_tgt;
    end

endmodule

// File: rtl/dll_lat_cnt.sv
module dll_lat_cnt #(
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LAT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);

    localparam logic [LAT_W-1:0] ONE = LAT_W'(1);

    logic [LAT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec && cnt_q != '0)
            cnt_q <= cnt_q - ONE;
    end

    assign last = (cnt_q == ONE);

endmodule

// File: rtl/dll_track_hold.sv
module dll_track_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic upd,
    input  logic sel_in,
    output logic track_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            track_q <= 1'b0;
        else if (upd)
            track_q <= sel_in;
    end

endmodule

// File: rtl/dll_pwr_seq.sv
module dll_pwr_seq
    import dll_pwr_pkg::*;
#(
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             warm_rst,
    input  logic             cfg_dll_en,
    input  logic             cfg_dll_idle,
    input  logic             cfg_track_sel,
    input  logic [1:0]       cfg_idle_act,
    input  logic [LAT_W-1:0] cfg_init_lat,
    input  logic             idle_req,
    input  logic             dll_locked,
    output logic             dll_pwrdn,
    output logic             dll_idle,
    output logic             dll_track,
    output logic             idle_ack,
    output logic             req_stall,
    output logic             idle_cfg_err
);

    dll_st_e  st_q, st_nxt, exit_st;
    dll_tgt_e tgt;
    logic     bad_act;
    logic     cnt_last, cnt_load;
    logic     track_upd;
    logic     ack_q, err_q;

    dll_tgt_sel u_tgt (
        .warm_rst     (warm_rst),
        .cfg_dll_en   (cfg_dll_en),
        .cfg_dll_idle (cfg_dll_idle),
        .cfg_idle_act (cfg_idle_act),
        .idle_req     (idle_req),
        .tgt          (tgt),
        .bad_act      (bad_act)
    );

    // exit path from a low-power state depends on the held flavour
    always_comb begin
        if (dll_track)
            exit_st = ST_LOCKWAIT;
        else if (cfg_init_lat == '0)
            exit_st = ST_ACTIVE;
        else
            exit_st = ST_FIXWAIT;
    end

    always_comb begin
        st_nxt = st_q;
        if (tgt == TGT_PDN) begin
            st_nxt = ST_PDN;
        end else if (tgt == TGT_IDL) begin
            st_nxt = ST_IDL;
        end else begin
            unique case (st_q)
                ST_PDN, ST_IDL: st_nxt = exit_st;
                ST_FIXWAIT:     st_nxt = cnt_last ? ST_ACTIVE : ST_FIXWAIT;
                ST_LOCKWAIT:    st_nxt = dll_locked ? ST_ACTIVE : ST_LOCKWAIT;
                ST_ACTIVE:      st_nxt = ST_ACTIVE;
                default:        st_nxt = ST_PDN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_PDN;
        else
            st_q <= st_nxt;
    end

    assign cnt_load = (st_nxt == ST_FIXWAIT) && (st_q != ST_FIXWAIT);

    dll_lat_cnt #(.LAT_W(LAT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cfg_init_lat),
        .dec      (st_q == ST_FIXWAIT),
        .last     (cnt_last)
    );

    // flavour sampled only on the four latch events
    assign track_upd = warm_rst
                     || (idle_req && !ack_q)
                     || (st_nxt == ST_PDN && st_q != ST_PDN)
                     || (st_nxt == ST_IDL && st_q != ST_IDL);

    dll_track_hold u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (track_upd),
        .sel_in  (cfg_track_sel),
        .track_q (dll_track)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            ack_q <= idle_req;
            err_q <= bad_act;
        end
    end

    always_comb begin
        dll_pwrdn    = (st_q == ST_PDN);
        dll_idle     = (st_q == ST_IDL);
        req_stall    = (st_q != ST_ACTIVE);
        idle_ack     = ack_q;
        idle_cfg_err = err_q;
    end

endmodule

// File: rtl/dll_pwr_seq_chk.sv
module dll_pwr_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       warm_rst,
    input logic [1:0] cfg_idle_act,
    input logic       idle_req,
    input logic       dll_locked,
    input logic       dll_pwrdn,
    input logic       dll_idle,
    input logic       dll_track,
    input logic       idle_ack,
    input logic       req_stall,
    input logic       idle_cfg_err
);

    assert_warm_pdn_R3: assert property (@(posedge clk) disable iff (!rst_n)
        warm_rst |=> dll_pwrdn);

    assert_act_pdn_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_req && cfg_idle_act == 2'd0) |=> dll_pwrdn);

    assert_act_idl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_req && !warm_rst && cfg_idle_act == 2'd1) |=> (dll_idle || dll_pwrdn));

    assert_ack_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        idle_req |=> idle_ack);

    assert_ack_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_req |=> !idle_ack);

    assert_err_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_req && cfg_idle_act[1]) |=> idle_cfg_err);

    assert_err_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_req || !cfg_idle_act[1]) |=> !idle_cfg_err);

    assert_lp_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (dll_pwrdn || dll_idle) |-> req_stall);

    assert_track_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dll_track) |-> ($past(warm_rst) || $past(idle_req && !idle_ack)
                                 || $rose(dll_pwrdn) || $rose(dll_idle)));

    assert_lock_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(req_stall) && $past(dll_track)) |-> $past(dll_locked));

endmodule

bind dll_pwr_seq dll_pwr_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .warm_rst     (warm_rst),
    .cfg_idle_act (cfg_idle_act),
    .idle_req     (idle_req),
    .dll_locked   (dll_locked),
    .dll_pwrdn    (dll_pwrdn),
    .dll_idle     (dll_idle),
    .dll_track    (dll_track),
    .idle_ack     (idle_ack),
    .req_stall    (req_stall),
    .idle_cfg_err (idle_cfg_err)
);

// File: tb/sim_dll_pwr_seq.sv
`timescale 1ns/1ps
module sim_dll_pwr_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       warm_rst = 1'b0;
    logic       cfg_dll_en = 1'b0;
    logic       cfg_dll_idle = 1'b0;
    logic       cfg_track_sel = 1'b0;
    logic [1:0] cfg_idle_act = 2'd0;
    logic [7:0] cfg_init_lat = 8'd0;
    logic       idle_req = 1'b0;
    logic       dll_locked = 1'b0;
    logic       dll_pwrdn, dll_idle, dll_track, idle_ack, req_stall, idle_cfg_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    dll_pwr_seq #(.LAT_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst),
        .cfg_dll_en(cfg_dll_en), .cfg_dll_idle(cfg_dll_idle),
        .cfg_track_sel(cfg_track_sel), .cfg_idle_act(cfg_idle_act),
        .cfg_init_lat(cfg_init_lat), .idle_req(idle_req), .dll_locked(dll_locked),
        .dll_pwrdn(dll_pwrdn), .dll_idle(dll_idle), .dll_track(dll_track),
        .idle_ack(idle_ack), .req_stall(req_stall), .idle_cfg_err(idle_cfg_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic set_cfg(input bit en, input bit idl, input bit trk,
                           input int act, input int lat);
        cfg_dll_en    = en;
        cfg_dll_idle  = idl;
        cfg_track_sel = trk;
        cfg_idle_act  = act[1:0];
        cfg_init_lat  = lat[7:0];
    endtask

    task automatic count_stall(input string tag, input int exp);
        int n = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (!req_stall) break;
            n++;
        end
        chk(tag, n, exp);
    endtask

    // behavioural reference: 0 pdn, 1 idle, 2 countdown, 3 lock wait, 4 run
    int m_st = 0, m_cnt = 0;
    bit m_trk = 0, m_ack = 0, m_err = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_trk = 0; m_ack = 0; m_err = 0;
        end else begin
            int want, base, nst;
            bit ev;
            base = !cfg_dll_en ? 0 : (cfg_dll_idle ? 1 : 4);
            want = base;
            if (idle_req && cfg_idle_act == 2'd0) want = 0;
            if (idle_req && cfg_idle_act == 2'd1) want = (base == 0) ? 0 : 1;
            if (warm_rst) want = 0;
            if (want != 4) nst = want;
            else if (m_st <= 1) begin
                if (m_trk) nst = 3;
                else if (cfg_init_lat == 0) nst = 4;
                else begin nst = 2; m_cnt = cfg_init_lat + 1; end
            end
            else if (m_st == 2) nst = (m_cnt == 1) ? 4 : 2;
            else if (m_st == 3) nst = dll_locked ? 4 : 3;
            else nst = 4;
            if (m_st == 2 || nst == 2) m_cnt = m_cnt - 1;
            ev = warm_rst || (idle_req && !m_ack) || (want == 0 && m_st != 0)
                 || (want == 1 && m_st != 1);
            if (ev) m_trk = cfg_track_sel;
            m_err = idle_req && cfg_idle_act >= 2'd2;
            m_ack = idle_req;
            m_st = nst;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 pwrdn", dll_pwrdn, m_st == 0);
            chk("R2 idle", dll_idle, m_st == 1);
            chk("R4 stall", req_stall, m_st != 4);
            chk("R7 track", dll_track, m_trk);
            chk("R10 ack", idle_ack, m_ack);
            chk("R9 err", idle_cfg_err, m_err);
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 pwrdn", dll_pwrdn, 1);
        chk("R1 idle", dll_idle, 0);
        chk("R1 track", dll_track, 0);
        chk("R1 stall", req_stall, 1);
        chk("R1 ack", idle_ack, 0);
        chk("R1 err", idle_cfg_err, 0);
        rst_n = 1'b1;
        @(negedge clk);

        set_cfg(1, 0, 0, 0, 5);
        count_stall("R4 fixed stall length", 5);
        set_cfg(0, 0, 0, 0, 5);
        repeat (2) @(negedge clk);
        chk("R2 disabled pwrdn", dll_pwrdn, 1);
        set_cfg(1, 0, 0, 0, 0);
        count_stall("R5 zero latency", 0);

        set_cfg(1, 0, 1, 0, 0);
        repeat (3) @(negedge clk);
        chk("R7 pending track", dll_track, 0);
        chk("R7 still running", req_stall, 0);
        set_cfg(1, 1, 1, 0, 0);
        @(negedge clk);
        chk("R2 idle entry", dll_idle, 1);
        chk("R7 track on idle", dll_track, 1);
        chk("R11 stall in idle", req_stall, 1);
        set_cfg(1, 0, 1, 0, 0);
        dll_locked = 1'b0;
        repeat (4) @(negedge clk);
        chk("R6 wait for lock", req_stall, 1);
        chk("R6 idle left", dll_idle, 0);
        dll_locked = 1'b1;
        @(negedge clk);
        chk("R6 release on lock", req_stall, 0);

        idle_req = 1'b1;
        @(negedge clk);
        chk("R8 act0 pwrdn", dll_pwrdn, 1);
        chk("R10 ack rise", idle_ack, 1);
        repeat (2) @(negedge clk);
        idle_req = 1'b0;
        @(negedge clk);
        chk("R10 ack fall", idle_ack, 0);
        chk("R10 left pwrdn", dll_pwrdn, 0);
        @(negedge clk);
        chk("R10 running again", req_stall, 0);

        set_cfg(1, 0, 1, 1, 0);
        idle_req = 1'b1;
        @(negedge clk);
        chk("R8 act1 idle", dll_idle, 1);
        idle_req = 1'b0;
        repeat (3) @(negedge clk);

        set_cfg(1, 0, 1, 2, 0);
        idle_req = 1'b1;
        @(negedge clk);
        chk("R9 err flag", idle_cfg_err, 1);
        chk("R9 no action", req_stall, 0);
        chk("R10 ack with act2", idle_ack, 1);
        idle_req = 1'b0;
        @(negedge clk);
        chk("R9 err clear", idle_cfg_err, 0);

        set_cfg(0, 0, 1, 1, 0);
        idle_req = 1'b1;
        @(negedge clk);
        chk("R8 cfg pwrdn wins", dll_pwrdn, 1);
        chk("R8 not idle", dll_idle, 0);
        idle_req = 1'b0;
        set_cfg(1, 0, 1, 0, 0);
        repeat (3) @(negedge clk);

        set_cfg(0, 1, 1, 0, 0);
        @(negedge clk);
        chk("R2 pwrdn over idle", dll_pwrdn, 1);
        chk("R2 idle suppressed", dll_idle, 0);
        chk("R11 stall in pwrdn", req_stall, 1);
        set_cfg(1, 0, 1, 0, 0);
        repeat (3) @(negedge clk);

        set_cfg(1, 0, 0, 0, 3);
        repeat (2) @(negedge clk);
        chk("R7 pending while running", dll_track, 1);
        warm_rst = 1'b1;
        @(negedge clk);
        chk("R3 warm pwrdn", dll_pwrdn, 1);
        chk("R3 warm latches flavour", dll_track, 0);
        warm_rst = 1'b0;
        count_stall("R3 R4 restart stall", 3);

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=0", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule